// File: doc/BRIEF.md
# Embedded operation status generator

This block produces the byte a host reads back from a flash array while a program or erase is running inside the device. It is started by the command decoder with the kind of operation, the target sector and bit 7 of the byte being written. It then answers every read strobe with a polled status word until the operation finishes. It also signals when the read path should return array data instead. The polled bits are a data-complement flag, two toggling flags, an error flag and an erase-started flag.

When the target of a program or erase is protected, the block does not start a real operation. It shows a dummy busy period of a fixed number of clock cycles and then returns to idle, so the array is never touched. A sector erase can be held in suspend. While it is held, reads outside the erasing sector go to the array and the internal time limit stops counting.

Top module: `emb_status_gen`

## Requirements
- R1: After reset, and whenever no operation is active, `status_o` is 8'h00 and `array_sel_o` is 1.
- R2: While a program runs, `status_o[7]` is the inverse of the `prog_d7_i` value captured at start. Bits 5, 3, 2, 1, 0 and 4 read 0 unless another requirement sets them. `array_sel_o` is 0.
- R3: While an erase runs and is not suspended, `status_o[7]` is 0. `status_o[3]` is 1 for a sector erase (`op_i`=2'b10) and 0 for a chip erase (`op_i`=2'b11).
- R4: While busy and not suspended, every cycle with `rd_i` high inverts `status_o[6]` from the next cycle on, whatever the address. Without strobes it holds. It starts at 0.
- R5: `status_o[2]` starts at 0. It inverts after a read strobe during a chip erase at any address, and during a sector erase only when `rd_addr_i` (address bits 17:13) decodes to the erasing sector. Decoding with the boot block at the top: 3C000h-3FFFFh is sector 6, 3A000h-3BFFFh is 5, 38000h-39FFFh is 4, 30000h-37FFFh is 3, and each lower 64K region is sector 0 to 2 by address bits 17:16.
- R6: A `done_i` pulse during a running, unsuspended, error-free operation returns the block to idle in the next cycle.
- R7: `timeout_i` during a running operation, or LIMIT_CYC unsuspended running cycles after start, sets `status_o[5]`. The bit then stays set, `done_i` is ignored, and when `timeout_i` and `done_i` arrive in the same cycle the error wins.
- R8: A program whose sector has its `prot_i` bit set stays busy for exactly PGM_FAKE_CYC cycles after the start edge, ignores `done_i` and `timeout_i`, then goes idle.
- R9: A sector erase of a protected sector, or a chip erase with all seven `prot_i` bits set, stays busy for exactly ERS_FAKE_CYC cycles and then goes idle. A chip erase with any sector unprotected runs for real.
- R10: While a running sector erase has `susp_i` high, `status_o[7]` reads 1 and `status_o[6]` holds. `status_o[2]` still inverts on reads in the erasing sector. `array_sel_o` is 1 for addresses outside that sector. The time limit does not advance and `done_i` is ignored.
- R11: A `start_i` pulse while busy is ignored.
- R12: `clr_i` returns the block to idle in the next cycle from any state and clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start of an operation from the command decoder |
| op_i | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 none |
| sect_i | input | 3 | Target sector of the program or sector erase |
| prog_d7_i | input | 1 | Bit 7 of the byte being programmed |
| prot_i | input | 7 | Protect bit per sector, bit n for sector n |
| rd_i | input | 1 | Read strobe, one per host read |
| rd_addr_i | input | 5 | Read address bits 17:13 |
| susp_i | input | 1 | Erase suspend acknowledged |
| timeout_i | input | 1 | External time or pulse limit exceeded |
| done_i | input | 1 | Embedded algorithm finished |
| clr_i | input | 1 | Reset command |
| status_o | output | 8 | Polled status word |
| array_sel_o | output | 1 | Read path should return array data |

## Verification
The completion pulse and the error condition can land on the same clock edge. Either an external timeout arrives together with `done_i`, or the internal limit expires in the cycle the algorithm reports completion. The bench drives `timeout_i` and `done_i` high in one cycle of a running program. It then expects the block to stay busy with bit 5 set and with bit 7 still showing the complement. A later `done_i` must change nothing, and only `clr_i` returns the block to idle.

// File: rtl/emb_status_gen.sv
module emb_status_gen #(
  parameter bit TOP_BOOT     = 1'b1,
  parameter int PGM_FAKE_CYC = 400,
  parameter int ERS_FAKE_CYC = 20000,
  parameter int LIMIT_CYC    = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic [2:0] sect_i,
  input  logic       prog_d7_i,
  input  logic [6:0] prot_i,
  input  logic       rd_i,
  input  logic [4:0] rd_addr_i,
  input  logic       susp_i,
  input  logic       timeout_i,
  input  logic       done_i,
  input  logic       clr_i,
  output logic [7:0] status_o,
  output logic       array_sel_o
);

  localparam int CNT_MAX = (LIMIT_CYC > ERS_FAKE_CYC) ?
                           ((LIMIT_CYC > PGM_FAKE_CYC) ? LIMIT_CYC : PGM_FAKE_CYC) :
                           ((ERS_FAKE_CYC > PGM_FAKE_CYC) ? ERS_FAKE_CYC : PGM_FAKE_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FAKE} st_t;

  st_t              st;
  logic [1:0]       op_q;
  logic [2:0]       sec_q;
  logic             d7_q, t6, t2, err;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       rd_sect;

  generate
    if (TOP_BOOT) begin : g_top
      assign rd_sect = (rd_addr_i[4:3] != 2'b11) ? {1'b0, rd_addr_i[4:3]} :
                       !rd_addr_i[2] ? 3'd3 :
                       rd_addr_i[1]  ? 3'd6 :
                       rd_addr_i[0]  ? 3'd5 : 3'd4;
    end else begin : g_bot
      assign rd_sect = (rd_addr_i[4:3] != 2'b00) ? 3'd3 + {1'b0, rd_addr_i[4:3]} :
                       rd_addr_i[2]  ? 3'd3 :
                       !rd_addr_i[1] ? 3'd0 :
                       !rd_addr_i[0] ? 3'd1 : 3'd2;
    end
  endgenerate

  wire is_prog  = (op_q == 2'b01);
  wire is_se    = (op_q == 2'b10);
  wire is_ce    = (op_q == 2'b11);
  wire busy     = (st != S_IDLE);
  wire run      = (st == S_RUN);
  wire susp_act = run && is_se && susp_i;
  wire in_sec   = (rd_sect == sec_q);
  wire hit2     = is_ce || (is_se && in_sec);
  wire lim_hit  = (cnt == CNT_W'(LIMIT_CYC - 1));
  wire win_end  = is_prog ? (cnt == CNT_W'(PGM_FAKE_CYC - 1))
                          : (cnt == CNT_W'(ERS_FAKE_CYC - 1));
  wire go_fake  = (op_i == 2'b11) ? (&prot_i) : prot_i[sect_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= 2'b00; sec_q <= 3'd0; d7_q <= 1'b0;
      t6 <= 1'b0; t2 <= 1'b0; err <= 1'b0; cnt <= '0;
    end else if (clr_i) begin
      st <= S_IDLE; t6 <= 1'b0; t2 <= 1'b0; err <= 1'b0; cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i && op_i != 2'b00) begin
          op_q  <= op_i;
          sec_q <= sect_i;
          d7_q  <= prog_d7_i;
          t6    <= 1'b0;
          t2    <= 1'b0;
          err   <= 1'b0;
          cnt   <= '0;
          st    <= go_fake ? S_FAKE : S_RUN;
        end
        S_RUN: begin
          if (rd_i) begin
            if (!susp_act) t6 <= ~t6;
            if (hit2)      t2 <= ~t2;
          end
          if (!susp_act && !err) begin
            if (timeout_i || lim_hit) err <= 1'b1;
            else if (done_i)          st  <= S_IDLE;
            else                      cnt <= cnt + CNT_W'(1);
          end
        end
        S_FAKE: begin
          if (rd_i) begin
            t6 <= ~t6;
            if (hit2) t2 <= ~t2;
          end
          if (win_end) st  <= S_IDLE;
          else         cnt <= cnt + CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire b7 = is_prog ? ~d7_q : susp_act;

  assign status_o    = busy ? {b7, t6, err, 1'b0, is_se, t2, 2'b00} : 8'h00;
  assign array_sel_o = !busy || (susp_act && !in_sec);

endmodule

module emb_status_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_i,
  input logic       clr_i,
  input logic       done_i,
  input logic       timeout_i,
  input logic [7:0] status_o,
  input logic       array_sel_o,
  input logic       run,
  input logic       susp_act
);

  // R4
  tog6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !susp_act && rd_i && !clr_i && !done_i)
      |=> (status_o[6] != $past(status_o[6])));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !susp_act && timeout_i && !clr_i) |=> status_o[5]);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && !clr_i) |=> status_o[5]);

  // R12
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (array_sel_o && status_o == 8'h00));

  // R10
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_act && !clr_i) |=> (run && status_o[6] == $past(status_o[6])));

  // R3
  ers_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && status_o[3] && !susp_act) |-> !status_o[7]);

endmodule

bind emb_status_gen emb_status_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .clr_i(clr_i), .done_i(done_i),
  .timeout_i(timeout_i), .status_o(status_o), .array_sel_o(array_sel_o),
  .run(run), .susp_act(susp_act)
);

// File: tb/emb_status_gen_tb.sv
`timescale 1ns/1ps
module emb_status_gen_tb;

  localparam int PGM_W = 8;
  localparam int ERS_W = 20;
  localparam int LIM   = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [2:0] sect_i = 3'd0;
  logic       prog_d7_i = 1'b0;
  logic [6:0] prot_i = 7'h00;
  logic       rd_i = 1'b0;
  logic [4:0] rd_addr_i = 5'd0;
  logic       susp_i = 1'b0;
  logic       timeout_i = 1'b0;
  logic       done_i = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] status_o;
  logic       array_sel_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  emb_status_gen #(.TOP_BOOT(1'b1), .PGM_FAKE_CYC(PGM_W),
                   .ERS_FAKE_CYC(ERS_W), .LIMIT_CYC(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sect_i(sect_i),
    .prog_d7_i(prog_d7_i), .prot_i(prot_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
    .susp_i(susp_i), .timeout_i(timeout_i), .done_i(done_i), .clr_i(clr_i),
    .status_o(status_o), .array_sel_o(array_sel_o)
  );

  // {op[1:0], sector[2:0], address[17:0], bit2 expected to toggle}
  localparam logic [23:0] VECS [10] = '{
    {2'd2, 3'd6, 18'h3C000, 1'b1},
    {2'd2, 3'd6, 18'h3BFFF, 1'b0},
    {2'd2, 3'd5, 18'h3A000, 1'b1},
    {2'd2, 3'd4, 18'h39FFF, 1'b1},
    {2'd2, 3'd3, 18'h37FFF, 1'b1},
    {2'd2, 3'd3, 18'h38000, 1'b0},
    {2'd2, 3'd0, 18'h0FFFF, 1'b1},
    {2'd2, 3'd1, 18'h20000, 1'b0},
    {2'd3, 3'd0, 18'h3FFFF, 1'b1},
    {2'd3, 3'd0, 18'h00000, 1'b1}
  };

  task automatic chk(input string tag, input logic [8:0] exp);
    checks++;
    if ({array_sel_o, status_o} !== exp) begin
      errors++;
      $display("FAIL %s: got sel=%0b status=%02h, expected sel=%0b status=%02h",
               tag, array_sel_o, status_o, exp[8], exp[7:0]);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [1:0] op, input logic [2:0] s, input logic d7);
    op_i = op; sect_i = s; prog_d7_i = d7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic rd(input logic [17:0] a);
    rd_addr_i = a[17:13]; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic clr();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic done();
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset idle", {1'b1, 8'h00});

    // R5: bit 2 address qualification, R4 bit 6 per read
    for (int i = 0; i < 10; i++) begin
      logic [7:0] base;
      base = (VECS[i][23:22] == 2'd2) ? 8'h08 : 8'h00;
      start(VECS[i][23:22], VECS[i][21:19], 1'b0);
      chk("R3 erase start", {1'b0, base});
      rd(VECS[i][18:1]);
      chk("R5 bit2 after read", {1'b0, base | 8'h40 | (VECS[i][0] ? 8'h04 : 8'h00)});
      clr();
      chk("R12 clear to idle", {1'b1, 8'h00});
    end

    // R2 / R4 / R11 / R6
    start(2'b01, 3'd0, 1'b0);
    chk("R2 program complement", {1'b0, 8'h80});
    cyc(5);
    chk("R4 hold without reads", {1'b0, 8'h80});
    rd(18'h00000);
    chk("R4 toggle 1", {1'b0, 8'hC0});
    rd(18'h3FFFF);
    chk("R4 toggle 2", {1'b0, 8'h80});
    rd(18'h12345);
    chk("R4 toggle 3", {1'b0, 8'hC0});
    start(2'b10, 3'd3, 1'b1);
    chk("R11 start ignored", {1'b0, 8'hC0});
    done();
    chk("R6 done to idle", {1'b1, 8'h00});

    // R2 with bit7 set, R7 timeout and done in the same cycle
    start(2'b01, 3'd4, 1'b1);
    chk("R2 program complement zero", {1'b0, 8'h00});
    timeout_i = 1'b1; done_i = 1'b1;
    @(negedge clk);
    timeout_i = 1'b0; done_i = 1'b0;
    chk("R7 error wins over done", {1'b0, 8'h20});
    done();
    chk("R7 done ignored after error", {1'b0, 8'h20});
    clr();
    chk("R12 clear error", {1'b1, 8'h00});

    // R7 internal limit
    start(2'b10, 3'd0, 1'b0);
    cyc(LIM - 1);
    chk("R7 before limit", {1'b0, 8'h08});
    cyc(1);
    chk("R7 at limit", {1'b0, 8'h28});
    clr();

    // R8 protected program
    prot_i = 7'b0000100;
    start(2'b01, 3'd2, 1'b0);
    chk("R8 fake busy", {1'b0, 8'h80});
    done();
    chk("R8 done ignored", {1'b0, 8'h80});
    cyc(PGM_W - 2);
    chk("R8 last busy cycle", {1'b0, 8'h80});
    cyc(1);
    chk("R8 window end", {1'b1, 8'h00});

    // R9 protected erases
    start(2'b10, 3'd2, 1'b0);
    cyc(ERS_W - 1);
    chk("R9 sector fake busy", {1'b0, 8'h08});
    cyc(1);
    chk("R9 sector fake end", {1'b1, 8'h00});
    prot_i = 7'h7F;
    start(2'b11, 3'd0, 1'b0);
    cyc(ERS_W - 1);
    chk("R9 chip fake busy", {1'b0, 8'h00});
    cyc(1);
    chk("R9 chip fake end", {1'b1, 8'h00});
    prot_i = 7'h7E;
    start(2'b11, 3'd0, 1'b0);
    cyc(ERS_W);
    chk("R9 partial protect runs", {1'b0, 8'h00});
    clr();
    prot_i = 7'h00;

    // R10 suspend
    start(2'b10, 3'd1, 1'b0);
    rd(18'h10000);
    chk("R10 pre-suspend", {1'b0, 8'h4C});
    susp_i = 1'b1;
    cyc(1);
    chk("R10 suspended bit7", {1'b0, 8'hCC});
    rd(18'h10000);
    chk("R10 bit6 held bit2 toggles", {1'b0, 8'hC8});
    rd(18'h00000);
    chk("R10 outside sector to array", {1'b1, 8'hC8});
    cyc(LIM + 20);
    done();
    chk("R10 limit frozen done ignored", {1'b1, 8'hC8});
    rd_addr_i = 5'b01000;
    #1;
    chk("R10 inside sector status", {1'b0, 8'hC8});
    susp_i = 1'b0;
    cyc(1);
    chk("R10 resumed", {1'b0, 8'h48});
    done();
    chk("R6 done after resume", {1'b1, 8'h00});

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule